// File: doc/BRIEF.md
# Indirect Register Access Port

This block puts a small host-visible window in front of a larger internal register file. The host sees six halfword slots: a status word, an indirect address register and four holding registers. Internal registers are 32 bits wide and are reached one transaction at a time. To write one, the host first loads the low half into the first holding register and the high half into the second. It then writes the indirect address register with bit 7 clear. To read one, the host writes the indirect address register with bit 7 set. Bit 0 of that address picks the low or the high half, and the returned halfword lands in the first holding register.

Each write to the indirect address register starts an internal transaction. A busy flag in the status word stays set for a fixed, parameterized number of cycles, and the host polls it until it clears. An address write that arrives while a transaction is still running is dropped and sets a sticky error flag. To set or clear a single bit, the host reads the register, changes the first holding register and writes the register back.

Top module: `ira_top`

## Requirements
- R1: After reset, the status word, the indirect address register and all four holding registers read as zero.
- R2: A host write to a holding register (window offsets 2 to 5) is read back unchanged from that offset.
- R3: An address write with bit 7 clear stores {holding1, holding0} into the internal entry selected by address bits [IDX_W:1]. Bit 0 is ignored for writes.
- R4: An address write with bit 7 set returns a halfword of the selected entry into holding0: the low half when bit 0 is 0, the high half when bit 0 is 1. Holding registers 1 to 3 are left unchanged.
- R5: The busy flag (status bit 0) is set in the cycle after an accepted address write. It stays set for exactly LATENCY cycles, so a poll of the status word that starts right after the write sees it set exactly LATENCY times.
- R6: An address write that arrives while busy is set has no effect on the internal file or on the indirect address register. It sets the overrun flag (status bit 1), which stays set until reset.
- R7: A read, a change of holding0 and a write back (with holding1 cleared) sets or clears a single bit of an entry's low half and leaves its high half zero.
- R8: Writes to the status offset (0) and to the unused offsets (6, 7) have no effect. The unused offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host write strobe for the slot at hst_addr |
| hst_addr | input | 3 | Window offset: 0 status, 1 indirect address, 2 to 5 holding 0 to 3 |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Registered read data of the slot addressed in the previous cycle |

## Verification
Write transactions are run to entries at both ends of the file and in the middle, with halves that differ per entry. This shows that the address bits select the entry and that the two halves are not swapped. The written entries are then read back with bit 0 both clear and set, which separates a correct half select from one tied to a single half. A write with bit 0 set tells whether that bit leaks into entry selection. Two address writes on back-to-back cycles separate a design that drops the second one from one that queues it or lets it overwrite the first. A bit set followed by a bit clear done through the holding register shows that reads and write-backs compose correctly.

// File: rtl/ira_pkg.sv
`timescale 1ns/1ps
package ira_pkg;
  localparam int HW     = 16;
  localparam int WIN_AW = 3;
  localparam int RD_BIT = 7;

  localparam logic [WIN_AW-1:0] OFF_STAT  = 3'd0;
  localparam logic [WIN_AW-1:0] OFF_IADDR = 3'd1;
  localparam int                HOLD_BASE = 2;

  typedef struct packed {
    logic rd;
    logic hi;
  } xact_kind_t;
endpackage

// File: rtl/ira_regfile.sv
`timescale 1ns/1ps
module ira_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [DEPTH];

  // single port, read-first, no reset: maps onto block RAM
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[idx] <= wdata;
      rdata <= mem[idx];
    end
  end
endmodule

// File: rtl/ira_xact_ctrl.sv
`timescale 1ns/1ps
module ira_xact_ctrl import ira_pkg::*; #(
  parameter int LAT   = 4,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  xact_kind_t       kind,
  input  logic [IDX_W-1:0] idx,
  input  logic [2*HW-1:0]  wdata,
  output logic             busy,
  output logic             mem_en,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_idx,
  output logic [2*HW-1:0]  mem_wdata,
  input  logic [2*HW-1:0]  mem_rdata,
  output logic             ret_valid,
  output logic [HW-1:0]    ret_data
);
  localparam int CW = $clog2(LAT + 1);

  if (LAT < 2) begin : g_bad_lat
    $error("ira_xact_ctrl: LAT must be at least 2");
  end

  logic [CW-1:0]    cnt;
  xact_kind_t       kind_q;
  logic [IDX_W-1:0] idx_q;
  logic [2*HW-1:0]  wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      kind_q <= '0;
      idx_q  <= '0;
      wd_q   <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= CW'(LAT);
      kind_q <= kind;
      idx_q  <= idx;
      wd_q   <= wdata;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) busy <= 1'b0;
    end
  end

  // memory is touched two cycles before completion: one for the
  // access, one for the registered read data
  assign mem_en    = busy && (cnt == CW'(2));
  assign mem_we    = mem_en && !kind_q.rd;
  assign mem_idx   = idx_q;
  assign mem_wdata = wd_q;

  assign ret_valid = busy && (cnt == CW'(1)) && kind_q.rd;
  assign ret_data  = kind_q.hi ? mem_rdata[2*HW-1:HW] : mem_rdata[HW-1:0];
endmodule

// File: rtl/ira_host_regs.sv
`timescale 1ns/1ps
module ira_host_regs import ira_pkg::*; #(
  parameter int NHOLD = 4,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_wr,
  input  logic [WIN_AW-1:0] hst_addr,
  input  logic [HW-1:0]     hst_wdata,
  input  logic              busy,
  input  logic              ret_valid,
  input  logic [HW-1:0]     ret_data,
  output logic              start,
  output xact_kind_t        kind,
  output logic [IDX_W-1:0]  idx,
  output logic [2*HW-1:0]   wdata,
  output logic              ovr,
  output logic [HW-1:0]     hold0,
  output logic [HW-1:0]     hst_rdata
);
  logic [NHOLD-1:0][HW-1:0] hold;
  logic [7:0]               iaddr_q;
  logic                     addr_hit;
  logic [HW-1:0]            rd_mux;

  assign addr_hit = hst_wr && (hst_addr == OFF_IADDR);
  assign start    = addr_hit && !busy;
  assign kind.rd  = hst_wdata[RD_BIT];
  assign kind.hi  = hst_wdata[0];
  assign idx      = hst_wdata[IDX_W:1];
  assign wdata    = {hold[1], hold[0]};
  assign hold0    = hold[0];

  for (genvar g = 0; g < NHOLD; g++) begin : g_hold
    logic [HW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (g == 0 && ret_valid)
        q <= ret_data;
      else if (hst_wr && hst_addr == WIN_AW'(HOLD_BASE + g))
        q <= hst_wdata;
    end
    assign hold[g] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iaddr_q <= '0;
      ovr     <= 1'b0;
    end else begin
      if (start)             iaddr_q <= hst_wdata[7:0];
      if (addr_hit && busy)  ovr     <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hst_addr == OFF_STAT)
      rd_mux = {{(HW-2){1'b0}}, ovr, busy};
    else if (hst_addr == OFF_IADDR)
      rd_mux = {{(HW-8){1'b0}}, iaddr_q};
    else
      for (int k = 0; k < NHOLD; k++)
        if (hst_addr == WIN_AW'(HOLD_BASE + k)) rd_mux = hold[k];
  end

  always_ff @(posedge clk) begin
    if (rst) hst_rdata <= '0;
    else     hst_rdata <= rd_mux;
  end
endmodule

// File: rtl/ira_top.sv
`timescale 1ns/1ps
module ira_top import ira_pkg::*; #(
  parameter int LATENCY = 4,
  parameter int NREGS   = 32,
  parameter int NHOLD   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_wr,
  input  logic [WIN_AW-1:0] hst_addr,
  input  logic [HW-1:0]     hst_wdata,
  output logic [HW-1:0]     hst_rdata
);
  localparam int IDX_W = $clog2(NREGS);

  logic             start_w, busy_w, ovr_w, ret_valid_w;
  xact_kind_t       kind_w;
  logic [IDX_W-1:0] idx_w, mem_idx_w;
  logic [2*HW-1:0]  wdata_w, mem_wdata_w, mem_rdata_w;
  logic [HW-1:0]    ret_data_w, hold0_w;
  logic             mem_en_w, mem_we_w;

  ira_host_regs #(.NHOLD(NHOLD), .IDX_W(IDX_W)) u_host (
    .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .busy(busy_w), .ret_valid(ret_valid_w),
    .ret_data(ret_data_w), .start(start_w), .kind(kind_w), .idx(idx_w),
    .wdata(wdata_w), .ovr(ovr_w), .hold0(hold0_w), .hst_rdata(hst_rdata)
  );

  ira_xact_ctrl #(.LAT(LATENCY), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start_w), .kind(kind_w), .idx(idx_w),
    .wdata(wdata_w), .busy(busy_w), .mem_en(mem_en_w), .mem_we(mem_we_w),
    .mem_idx(mem_idx_w), .mem_wdata(mem_wdata_w), .mem_rdata(mem_rdata_w),
    .ret_valid(ret_valid_w), .ret_data(ret_data_w)
  );

  ira_regfile #(.W(2*HW), .DEPTH(NREGS), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .en(mem_en_w), .we(mem_we_w), .idx(mem_idx_w),
    .wdata(mem_wdata_w), .rdata(mem_rdata_w)
  );
endmodule

// File: rtl/ira_checker.sv
`timescale 1ns/1ps
module ira_checker import ira_pkg::*; #(
  parameter int LAT = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              hst_wr,
  input logic [WIN_AW-1:0] hst_addr,
  input logic              busy,
  input logic              ovr,
  input logic [HW-1:0]     hold0
);
  logic rst_d = 1'b1;
  int   bcnt  = 0;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst || !busy) bcnt <= 0;
    else              bcnt <= bcnt + 1;
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (hold0 == '0 && !busy && !ovr));

  p_busy_starts_r5: assert property (@(posedge clk) disable iff (rst)
    (hst_wr && hst_addr == OFF_IADDR && !busy) |=> busy);

  p_busy_bounded_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bcnt < LAT));

  p_busy_exact_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == LAT));

  p_overrun_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (hst_wr && hst_addr == OFF_IADDR && busy) |=> ovr);

  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    ovr |=> ovr);

  p_hold0_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(hst_wr && hst_addr == WIN_AW'(HOLD_BASE))) |=> $stable(hold0));
endmodule

bind ira_top ira_checker #(.LAT(LATENCY)) u_chk (
  .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_addr(hst_addr),
  .busy(busy_w), .ovr(ovr_w), .hold0(hold0_w)
);

// File: tb/tb_ira_top.sv
`timescale 1ns/1ps
module tb_ira_top;
  localparam int LAT   = 4;
  localparam int NREGS = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_wr = 1'b0;
  logic [2:0]  hst_addr = '0;
  logic [15:0] hst_wdata = '0;
  logic [15:0] hst_rdata;

  always #5 clk = ~clk;

  ira_top #(.LATENCY(LAT), .NREGS(NREGS)) dut (
    .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [15:0] exp_q [$];
  string       tag_q [$];
  bit          mon_go = 0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares the registered read data one cycle after the request
  always @(negedge clk) begin
    if (mon_go) begin
      logic [15:0] e;
      string t;
      mon_go = 0;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, hst_rdata, e);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    hst_wr = 1'b0; hst_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
    #1 mon_go = 1;
  endtask

  // called at the negedge right after an address write
  task automatic poll(output int n);
    logic [15:0] v;
    n = 0;
    hst_addr = 3'd0;
    do begin
      @(negedge clk);
      v = hst_rdata;
      if (v[0]) n++;
    end while (v[0] && n < 50);
  endtask

  task automatic xact(input logic [7:0] a, output int n);
    wr(3'd1, {8'h00, a});
    poll(n);
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    for (int k = 0; k < 6; k++) exp_rd(3'(k), 16'h0000, $sformatf("R1 offset %0d after reset", k));

    // R2 holding registers read back
    for (int k = 0; k < 4; k++) wr(3'(2 + k), 16'hA5A0 + 16'(k) * 16'h0111);
    for (int k = 0; k < 4; k++) exp_rd(3'(2 + k), 16'hA5A0 + 16'(k) * 16'h0111, $sformatf("R2 holding%0d", k));

    // R3/R4/R5 writes and reads at several entries
    for (int j = 0; j < 4; j++) begin
      int idx;
      logic [15:0] lo, hi;
      idx = (j == 0) ? 0 : (j == 1) ? 5 : (j == 2) ? 17 : 31;
      lo  = 16'(idx) * 16'h1111 + 16'h0007;
      hi  = 16'(idx) * 16'h0101 ^ 16'hC3C3;
      wr(3'd2, lo);
      wr(3'd3, hi);
      xact(8'(idx << 1), n);
      check($sformatf("R5 busy samples after write idx %0d", idx), 16'(n), 16'(LAT));
      wr(3'd4, 16'h5A5A);
      wr(3'd3, 16'h0F0F);
      xact(8'h80 | 8'(idx << 1), n);
      check($sformatf("R5 busy samples after read idx %0d", idx), 16'(n), 16'(LAT));
      exp_rd(3'd2, lo, $sformatf("R3 R4 low half idx %0d", idx));
      xact(8'h81 | 8'(idx << 1), n);
      exp_rd(3'd2, hi, $sformatf("R3 R4 high half idx %0d", idx));
      exp_rd(3'd3, 16'h0F0F, "R4 holding1 untouched by read");
      exp_rd(3'd4, 16'h5A5A, "R4 holding2 untouched by read");
    end

    // R3 bit 0 ignored on writes
    wr(3'd2, 16'h1111);
    wr(3'd3, 16'h2222);
    xact(8'h0B, n);
    xact(8'h8A, n);
    exp_rd(3'd2, 16'h1111, "R3 write with bit0 set, low half");
    xact(8'h8B, n);
    exp_rd(3'd2, 16'h2222, "R3 write with bit0 set, high half");

    // R6 address write while busy
    wr(3'd2, 16'h0909);
    wr(3'd3, 16'h0000);
    xact(8'h12, n);
    exp_rd(3'd0, 16'h0000, "R6 no overrun before collision");
    wr(3'd2, 16'hDEAD);
    wr(3'd1, 16'h0014);
    wr(3'd1, 16'h0012);
    poll(n);
    exp_rd(3'd0, 16'h0002, "R6 overrun flag set");
    exp_rd(3'd1, 16'h0014, "R6 address register keeps accepted value");
    xact(8'h92, n);
    exp_rd(3'd2, 16'h0909, "R6 dropped write left entry 9");
    xact(8'h94, n);
    exp_rd(3'd2, 16'hDEAD, "R6 accepted write reached entry 10");
    exp_rd(3'd0, 16'h0002, "R6 overrun flag sticky");

    // R8 status and unused offsets
    wr(3'd0, 16'h0000);
    exp_rd(3'd0, 16'h0002, "R8 status write ignored");
    wr(3'd6, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    exp_rd(3'd6, 16'h0000, "R8 offset 6 reads zero");
    exp_rd(3'd7, 16'h0000, "R8 offset 7 reads zero");

    // R7 bit set then bit clear on entry 5 (low 1111, high 2222)
    xact(8'h8A, n);
    exp_rd(3'd2, 16'h1111, "R7 read before set");
    wr(3'd2, 16'h1111 | 16'h0080);
    wr(3'd3, 16'h0000);
    xact(8'h0A, n);
    xact(8'h8A, n);
    exp_rd(3'd2, 16'h1191, "R7 bit set low half");
    xact(8'h8B, n);
    exp_rd(3'd2, 16'h0000, "R7 high half cleared by write back");
    xact(8'h8A, n);
    wr(3'd2, 16'h1191 & ~16'h0010);
    wr(3'd3, 16'h0000);
    xact(8'h0A, n);
    xact(8'h8A, n);
    exp_rd(3'd2, 16'h1181, "R7 bit clear low half");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule